// File: doc/BRIEF.md
# Periodic Down-Counting System Tick Timer

This block is a periodic timer for a processor subsystem. A counter of configurable width (24 bits by default) counts down from a programmable start value. When it steps from one to zero it latches a sticky status flag and can emit a one-cycle interrupt request. On the following count step it reloads the start value. Software reaches four word registers through a minimal synchronous bus: a control/status word, the start value, the live count, and a read-only calibration constant.

The counting step is either every bus clock cycle or one cycle in eight. A source-select control bit chooses between them. The slow rate comes from a small free-running prescaler, which restarts whenever the counter is switched on. Reading the control/status word reports the sticky flag and clears it. A write of any data to the live-count register zeroes both the count and the flag. If the start value is zero, the counter parks at zero at its next wrap.

Top module: `tick_timer_top`

## Requirements
- R1: After reset, the control/status, start-value and live-count registers read 0, and the interrupt output is 0.
- R2: `bus_word` selects the register: 0 is control/status, 1 is start value, 2 is live count, 3 is calibration. In control/status, bit 0 is run enable, bit 1 is interrupt enable, bit 2 is source select and bit 16 is the sticky flag; all other bits read 0. The start value occupies bits 23:0 and bits 31:24 read 0. Read data appears on `bus_rdata` one cycle after the read strobe and holds until the next read.
- R3: The calibration word always reads 0xC0000000, and writes to it have no effect.
- R4: While run enable is 1, each count step decrements a nonzero count. A step taken at zero loads the start value. While run enable is 0, the count holds.
- R5: A step from 1 to 0 sets the sticky flag. A control/status read returns the flag and clears it.
- R6: A step from 1 to 0 with interrupt enable set gives a one-cycle pulse on `irq_pulse`. There is no pulse when interrupt enable is 0, and none while run enable is 0.
- R7: A write of any data to the live-count register sets the count and the flag to 0 and gives no interrupt pulse.
- R8: With a start value of 0, a step taken at zero leaves the count at zero.
- R9: With source select 1, a count step occurs every cycle. With source select 0, a step occurs every 8 cycles, and the first step comes on the 8th clock edge after the write that turns run enable from 0 to 1.
- R10: When a control/status read coincides with the step from 1 to 0, the read returns the old flag and the flag ends at 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one transfer per cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_word | input | 2 | Register word index |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| irq_pulse | output | 1 | One-cycle interrupt request |

## Verification
Every result of this block is due one clock edge after its cause. Read data is registered on the edge that samples the strobe. The flag, the count and the interrupt pulse move on the edge that takes the count step. On the slow source, the step falls on the eighth edge after the enabling write. The bench drives its stimulus on falling edges and advances a behavioural model on each rising edge. It compares `bus_rdata` and `irq_pulse` against that model at every following falling edge, so each expected value is sampled exactly one edge after its cause.

// File: rtl/tick_timer_pkg.sv
package tick_timer_pkg;
  localparam int unsigned DATA_W   = 32;
  localparam int unsigned BIT_RUN  = 0;
  localparam int unsigned BIT_IRQE = 1;
  localparam int unsigned BIT_FAST = 2;
  localparam int unsigned BIT_FLAG = 16;

  typedef enum logic [1:0] {
    W_CTRL  = 2'd0,
    W_START = 2'd1,
    W_LIVE  = 2'd2,
    W_CALIB = 2'd3
  } word_e;

  typedef struct packed {
    logic fast;
    logic irq_en;
    logic run;
  } ctrl_t;
endpackage

// File: rtl/tick_prescaler.sv
module tick_prescaler #(
  parameter int unsigned PSC_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic restart,
  output logic slow_tick
);
  logic [PSC_W-1:0] psc;

  always_ff @(posedge clk) begin
    if (rst || restart) psc <= '0;
    else                psc <= psc + PSC_W'(1);
  end

  assign slow_tick = (psc == '1);

  // R9: slow ticks are never back to back
  a_r9_slow_spacing: assert property (@(posedge clk) disable iff (rst)
    slow_tick |=> !slow_tick);
  // R9: a restart puts the first tick a full period away
  a_r9_restart_gap: assert property (@(posedge clk) disable iff (rst)
    restart |=> !slow_tick);
endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter logic [31:0] CALIB_VALUE = 32'hC000_0000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel,
  input  logic              wr,
  input  logic [1:0]        word,
  input  logic [DATA_W-1:0] wdata,
  input  logic [CNT_W-1:0]  live,
  input  logic              flag,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  start_val,
  output logic              run_start,
  output logic              live_clear,
  output logic              ctrl_read,
  output logic [DATA_W-1:0] rdata
);
  word_e             wsel;
  logic              do_wr, do_rd;
  logic [DATA_W-1:0] rd_mux;
  logic              unused_hi;

  assign wsel       = word_e'(word);
  assign do_wr      = sel && wr;
  assign do_rd      = sel && !wr;
  assign run_start  = do_wr && (wsel == W_CTRL) && wdata[BIT_RUN] && !ctrl.run;
  assign live_clear = do_wr && (wsel == W_LIVE);
  assign ctrl_read  = do_rd && (wsel == W_CTRL);
  assign unused_hi  = ^wdata[DATA_W-1:CNT_W];

  always_comb begin
    rd_mux = '0;
    unique case (wsel)
      W_CTRL: begin
        rd_mux[BIT_RUN]  = ctrl.run;
        rd_mux[BIT_IRQE] = ctrl.irq_en;
        rd_mux[BIT_FAST] = ctrl.fast;
        rd_mux[BIT_FLAG] = flag;
      end
      W_START: rd_mux = DATA_W'(start_val);
      W_LIVE:  rd_mux = DATA_W'(live);
      W_CALIB: rd_mux = CALIB_VALUE;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl      <= '0;
      start_val <= '0;
      rdata     <= '0;
    end else begin
      if (do_wr && wsel == W_CTRL) begin
        ctrl.run    <= wdata[BIT_RUN];
        ctrl.irq_en <= wdata[BIT_IRQE];
        ctrl.fast   <= wdata[BIT_FAST];
      end
      if (do_wr && wsel == W_START) start_val <= wdata[CNT_W-1:0];
      if (do_rd) rdata <= rd_mux;
    end
  end

  // R3: calibration reads are constant
  a_r3_calib_const: assert property (@(posedge clk) disable iff (rst)
    (do_rd && wsel == W_CALIB) |=> (rdata == CALIB_VALUE));
  // R2: read data holds between reads
  a_r2_rdata_hold: assert property (@(posedge clk) disable iff (rst)
    !do_rd |=> $stable(rdata));
  // R5: a control read reports the flag seen in its own cycle
  a_r5_flag_report: assert property (@(posedge clk) disable iff (rst)
    ctrl_read |=> (rdata[BIT_FLAG] == $past(flag)));
endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int unsigned CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic             irq_en,
  input  logic             fast,
  input  logic             slow_tick,
  input  logic [CNT_W-1:0] start_val,
  input  logic             live_clear,
  input  logic             ctrl_read,
  output logic [CNT_W-1:0] live,
  output logic             flag,
  output logic             irq
);
  logic step, hit_zero;

  assign step     = run && (fast || slow_tick);
  assign hit_zero = step && (live == CNT_W'(1)) && !live_clear;

  always_ff @(posedge clk) begin
    if (rst) begin
      live <= '0;
      flag <= 1'b0;
      irq  <= 1'b0;
    end else begin
      if (live_clear)        live <= '0;
      else if (step) begin
        if (live == '0)      live <= start_val;
        else                 live <= live - CNT_W'(1);
      end
      if (live_clear)        flag <= 1'b0;
      else if (hit_zero)     flag <= 1'b1;
      else if (ctrl_read)    flag <= 1'b0;
      irq <= hit_zero && irq_en;
    end
  end

  // R4: a step on a nonzero count decrements by one
  a_r4_decrement: assert property (@(posedge clk) disable iff (rst)
    (step && live != '0 && !live_clear) |=> (live == $past(live) - CNT_W'(1)));
  // R4: no step while disabled
  a_r4_hold_off: assert property (@(posedge clk) disable iff (rst)
    (!run && !live_clear) |=> $stable(live));
  // R6: the request never follows a disabled cycle
  a_r6_irq_needs_run: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(run));
  // R6: the request lasts one cycle
  a_r6_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  // R7: a live-count write clears state without a request
  a_r7_live_clear: assert property (@(posedge clk) disable iff (rst)
    live_clear |=> (live == '0 && !flag && !irq));
  // R8: a zero start value parks the count
  a_r8_park_zero: assert property (@(posedge clk) disable iff (rst)
    (step && live == '0 && start_val == '0 && !live_clear) |=> (live == '0));
  // R10: the set beats a concurrent read
  a_r10_set_wins: assert property (@(posedge clk) disable iff (rst)
    (step && live == CNT_W'(1) && !live_clear) |=> flag);
endmodule

// File: rtl/tick_timer_top.sv
module tick_timer_top
  import tick_timer_pkg::*;
#(
  parameter int unsigned CNT_W       = 24,
  parameter int unsigned PSC_W       = 3,
  parameter logic [31:0] CALIB_VALUE = 32'hC000_0000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [1:0]  bus_word,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        irq_pulse
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] start_val, live;
  logic             flag, run_start, live_clear, ctrl_read, slow_tick;

  tick_regs #(.CNT_W(CNT_W), .CALIB_VALUE(CALIB_VALUE)) u_regs (
    .clk(clk), .rst(rst), .sel(bus_sel), .wr(bus_wr), .word(bus_word),
    .wdata(bus_wdata), .live(live), .flag(flag), .ctrl(ctrl),
    .start_val(start_val), .run_start(run_start), .live_clear(live_clear),
    .ctrl_read(ctrl_read), .rdata(bus_rdata)
  );

  tick_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk(clk), .rst(rst), .restart(run_start), .slow_tick(slow_tick)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .run(ctrl.run), .irq_en(ctrl.irq_en),
    .fast(ctrl.fast), .slow_tick(slow_tick), .start_val(start_val),
    .live_clear(live_clear), .ctrl_read(ctrl_read), .live(live),
    .flag(flag), .irq(irq_pulse)
  );
endmodule

// File: tb/tb_tick_timer_top.sv
module tb_tick_timer_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0]  bus_word = 2'd0;
  logic [31:0] bus_wdata = 32'd0;
  logic [31:0] bus_rdata;
  logic        irq_pulse;

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string req = "R1";
  bit    armed = 1'b0, done = 1'b0;

  always #2.5 clk = ~clk;

  tick_timer_top dut (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_word(bus_word), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_pulse(irq_pulse)
  );

  // behavioural reference
  int          m_live, m_start, m_psc;
  bit          m_run, m_irqe, m_fast, m_flag, exp_irq;
  logic [31:0] exp_rdata;

  always @(posedge clk) begin
    bit stp, wrc, rdc, setf;
    if (rst) begin
      m_live = 0; m_start = 0; m_psc = 0; m_run = 0; m_irqe = 0; m_fast = 0;
      m_flag = 0; exp_irq = 0; exp_rdata = 32'd0;
    end else begin
      stp = m_run && (m_fast || m_psc == 7);
      wrc = bus_sel && bus_wr;
      rdc = bus_sel && !bus_wr;
      if (rdc) begin
        case (bus_word)
          2'd0: exp_rdata = {15'd0, m_flag, 13'd0, m_fast, m_irqe, m_run};
          2'd1: exp_rdata = 32'(m_start);
          2'd2: exp_rdata = 32'(m_live);
          default: exp_rdata = 32'hC000_0000;
        endcase
      end
      setf = stp && m_live == 1 && !(wrc && bus_word == 2'd2);
      exp_irq = setf && m_irqe;
      if (wrc && bus_word == 2'd2) begin
        m_live = 0; m_flag = 0;
      end else begin
        if (stp) m_live = (m_live == 0) ? m_start : m_live - 1;
        if (setf) m_flag = 1;
        else if (rdc && bus_word == 2'd0) m_flag = 0;
      end
      if (wrc && bus_word == 2'd0 && bus_wdata[0] && !m_run) m_psc = 0;
      else m_psc = (m_psc + 1) % 8;
      if (wrc && bus_word == 2'd0) begin
        m_run = bus_wdata[0]; m_irqe = bus_wdata[1]; m_fast = bus_wdata[2];
      end
      if (wrc && bus_word == 2'd1) m_start = int'(bus_wdata[23:0]);
    end
  end

  always @(negedge clk) begin
    if (armed) begin
      n_cmp++;
      if (bus_rdata !== exp_rdata) begin
        n_bad++;
        $display("FAIL %s rdata actual %h expected %h", req, bus_rdata, exp_rdata);
      end
      n_cmp++;
      if (irq_pulse !== exp_irq) begin
        n_bad++;
        $display("FAIL %s irq actual %b expected %b", req, irq_pulse, exp_irq);
      end
    end
  end

  task automatic finish_run();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      n_bad++;
      $display("FAIL watchdog actual %0d cycles expected completion", cyc);
      finish_run();
    end
  end

  task automatic wr_reg(input logic [1:0] w, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_word = w; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd_burst(input logic [1:0] w, input int n);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_word = w;
    repeat (n) @(negedge clk);
    bus_sel = 0;
  endtask

  task automatic expect_rd(input logic [1:0] w, input logic [31:0] e, input string tag);
    rd_burst(w, 1);
    n_cmp++;
    if (bus_rdata !== e) begin
      n_bad++;
      $display("FAIL %s direct actual %h expected %h", tag, bus_rdata, e);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    armed = 1;
    req = "R1";
    expect_rd(2'd0, 32'h0, "R1");
    expect_rd(2'd1, 32'h0, "R1");
    expect_rd(2'd2, 32'h0, "R1");
    req = "R3";
    expect_rd(2'd3, 32'hC000_0000, "R3");
    wr_reg(2'd3, 32'h1234_5678);
    expect_rd(2'd3, 32'hC000_0000, "R3");
    req = "R2";
    wr_reg(2'd1, 32'hFFFF_FFFF);
    expect_rd(2'd1, 32'h00FF_FFFF, "R2");
    wr_reg(2'd0, 32'hFFFF_FFF8);
    expect_rd(2'd0, 32'h0, "R2");
    idle(3);

    req = "R4";
    wr_reg(2'd1, 32'd5);
    wr_reg(2'd0, 32'd7);
    for (int i = 0; i < 6; i++) rd_burst(2'd2, 1);
    req = "R5";
    rd_burst(2'd0, 1);
    rd_burst(2'd0, 1);
    req = "R6";
    idle(20);
    wr_reg(2'd0, 32'd5);
    idle(20);
    rd_burst(2'd0, 1);

    req = "R7";
    wr_reg(2'd0, 32'd7);
    idle(3);
    wr_reg(2'd2, 32'hDEAD_BEEF);
    rd_burst(2'd2, 1);
    rd_burst(2'd0, 1);
    idle(13);

    req = "R4";
    wr_reg(2'd0, 32'd2);
    rd_burst(2'd2, 3);
    idle(5);
    rd_burst(2'd2, 1);

    req = "R9";
    wr_reg(2'd1, 32'd3);
    wr_reg(2'd0, 32'd3);
    rd_burst(2'd2, 40);
    idle(30);
    wr_reg(2'd0, 32'd0);
    wr_reg(2'd0, 32'd3);
    rd_burst(2'd2, 20);

    req = "R10";
    wr_reg(2'd1, 32'd2);
    wr_reg(2'd0, 32'd7);
    rd_burst(2'd0, 12);
    rd_burst(2'd0, 1);

    req = "R8";
    wr_reg(2'd1, 32'd0);
    idle(6);
    rd_burst(2'd2, 4);
    idle(10);
    rd_burst(2'd2, 2);
    wr_reg(2'd1, 32'd4);
    rd_burst(2'd2, 8);
    wr_reg(2'd0, 32'd0);
    idle(4);

    done = 1;
    finish_run();
  end
endmodule